// File: doc/BRIEF.md
# Ethernet Transmit Clock and Interface Mode Glue

This block sits beside an Ethernet MAC and turns one 32-bit configuration word into the clocking and interface-mode controls that face an external PHY. It takes two reference clock enables, selects one, divides the selected strobe train by a programmable code, halves the result and gates it to form the transmit clock. The transmit clock can be skewed in quarter-period steps against an undelayed copy that drives the PHY reference clock output. All clocks are strobes or levels inside one fast system clock domain. Software writes the word through a single write port and can read it back.

The interface mode (RGMII or RMII) is decoded from the low bits of the word. One decode uses a single bit and a parameter selects a three-bit decode. In RMII mode the transmit skew is ignored and the reference-clock inversion flag may be driven. Changes to the divider code, the input select and the skew code wait for the end of the running output period, so the output never shows a shortened phase.

Top module: `eth_clkglue`

## Requirements
- R1: Bit 4 of the word selects the counted reference: 0 counts `ref_en0` strobes and 1 counts `ref_en1` strobes. Strobes on the other input have no effect on either clock output.
- R2: Bits 9:7 hold the divider code N. For codes 2 to 7, `phy_ref_o` is high for N counted strobes and low for N counted strobes, for a period of 2N.
- R3: Divider codes 0 and 1 behave as code 2, so the outputs keep toggling with a period of 4 strobes.
- R4: When bit 10 is clear, `tx_clk_o` stays low and `phy_ref_o` keeps toggling.
- R5: When bit 12 is clear, both `tx_clk_o` and `phy_ref_o` stay low.
- R6: In RGMII mode, bits 6:5 hold a skew code d (0 to 3). `tx_clk_o` equals `phy_ref_o` delayed by floor(d*N/2) counted strobes, which is d quarter periods rounded down to whole strobes.
- R7: In RMII mode the skew code has no effect and `tx_clk_o` equals `phy_ref_o` (zero delay).
- R8: `rmii_inv_o` is bit 11 in RMII mode and is low in RGMII mode.
- R9: With parameter ALT_MODE=0, bit 0 set selects RGMII (`rgmii_mode_o`=1) and bit 0 clear selects RMII.
- R10: With ALT_MODE=1, bits 2:0 equal to 1 select RGMII and equal to 4 select RMII. Any other value selects RMII, and a write of such a value sets `mode_err_o`, which stays set until reset.
- R11: A new divider code, input select or skew code takes effect only at the end of a full output period. Every complete high or low phase has the old or the new length N and never an intermediate length.
- R12: After reset the word reads back as parameter CFG_RST (default 0), both clock outputs are low and `mode_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | DATA_W | Data to write |
| cfg_rdata | output | DATA_W | Current configuration word |
| ref_en0 | input | 1 | Reference clock enable, input 0 |
| ref_en1 | input | 1 | Reference clock enable, input 1 |
| tx_clk_o | output | 1 | Gated, skewed transmit clock level |
| phy_ref_o | output | 1 | Undelayed divided clock for the PHY reference |
| rgmii_mode_o | output | 1 | 1 = RGMII, 0 = RMII |
| rmii_inv_o | output | 1 | RMII reference clock inversion |
| mode_err_o | output | 1 | Sticky flag for an invalid mode code (three-bit decode only) |

## Verification
The checker watches every cycle for the gating rules: a cleared generator enable silences both outputs and a cleared gate silences the transmit clock, one cycle later. It also checks that the inversion flag never appears in RGMII mode, that the error flag never falls, that the active divider never goes below two, and that the active settings change only on a period wrap. Run lengths, the quarter-period skew against the reference output, input selection, and the rounding of codes 0 and 1 depend on whole strobe sequences. The bench scenarios show these by sampling both outputs once per strobe and comparing the sampled waves.

// File: rtl/eth_clkglue_pkg.sv
package eth_clkglue_pkg;

    localparam int DIV_CODE_W = 3;
    localparam int MIN_DIV    = 2;
    localparam int DLY_W      = 2;

    // Field positions inside the configuration word.
    localparam int POS_MODE0  = 0;
    localparam int POS_SEL    = 4;
    localparam int POS_DLY    = 5;
    localparam int POS_CODE   = 7;
    localparam int POS_GATE   = 10;
    localparam int POS_INV    = 11;
    localparam int POS_GEN    = 12;

    localparam logic [2:0] ALT_RGMII = 3'd1;
    localparam logic [2:0] ALT_RMII  = 3'd4;

    typedef struct packed {
        logic                  rgmii;
        logic                  inv;
        logic                  gate;
        logic                  gen;
        logic                  sel;
        logic [DLY_W-1:0]      dly;
        logic [DIV_CODE_W-1:0] code;
    } cfg_fields_t;

    function automatic logic [DIV_CODE_W-1:0] div_of(input logic [DIV_CODE_W-1:0] code);
        if (code < DIV_CODE_W'(MIN_DIV)) begin
            return DIV_CODE_W'(MIN_DIV);
        end
        return code;
    endfunction

endpackage

// File: rtl/ecg_cfg_regs.sv
module ecg_cfg_regs
    import eth_clkglue_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter bit          ALT_MODE = 1'b0,
    parameter logic [31:0] CFG_RST  = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] word_o,
    output cfg_fields_t       fields_o,
    output logic              err_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              err;
    } regs_t;

    regs_t st_d, st_q;
    logic  bad_code;

    always_comb begin
        st_d     = st_q;
        bad_code = (wdata_i[2:0] != ALT_RGMII) && (wdata_i[2:0] != ALT_RMII);
        if (we_i) begin
            st_d.word = wdata_i;
            if (ALT_MODE && bad_code) begin
                st_d.err = 1'b1;
            end
        end

        if (ALT_MODE) begin
            fields_o.rgmii = (st_q.word[2:0] == ALT_RGMII);
        end else begin
            fields_o.rgmii = st_q.word[POS_MODE0];
        end
        fields_o.sel  = st_q.word[POS_SEL];
        fields_o.dly  = st_q.word[POS_DLY +: DLY_W];
        fields_o.code = st_q.word[POS_CODE +: DIV_CODE_W];
        fields_o.gate = st_q.word[POS_GATE];
        fields_o.inv  = st_q.word[POS_INV] & ~fields_o.rgmii;
        fields_o.gen  = st_q.word[POS_GEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= DATA_W'(CFG_RST);
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign err_o  = st_q.err;

endmodule

// File: rtl/ecg_div_chain.sv
module ecg_div_chain
    import eth_clkglue_pkg::*;
#(
    parameter int                    CODE_W   = DIV_CODE_W,
    parameter int                    D_W      = DLY_W,
    parameter logic                  RST_SEL  = 1'b0,
    parameter logic [CODE_W-1:0]     RST_CODE = '0,
    parameter logic [D_W-1:0]        RST_DLY  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en0,
    input  logic              ref_en1,
    input  logic              sel_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [D_W-1:0]    dly_i,
    output logic [CODE_W-1:0] cnt_o,
    output logic              half_o,
    output logic [CODE_W-1:0] n_o,
    output logic [D_W-1:0]    dly_o,
    output logic              sel_o,
    output logic              wrap_o
);

    typedef struct packed {
        logic [CODE_W-1:0] cnt;
        logic              half;
        logic [CODE_W-1:0] n;
        logic [D_W-1:0]    dly;
        logic              sel;
    } chain_t;

    localparam logic [CODE_W-1:0] RST_N = (RST_CODE < CODE_W'(MIN_DIV)) ? CODE_W'(MIN_DIV) : RST_CODE;

    chain_t st_d, st_q;
    logic   strobe;
    logic   last;

    always_comb begin
        st_d   = st_q;
        strobe = st_q.sel ? ref_en1 : ref_en0;
        last   = (st_q.cnt == st_q.n - CODE_W'(1));
        wrap_o = strobe & last & st_q.half;
        if (strobe) begin
            if (last) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                if (st_q.half) begin
                    st_d.sel = sel_i;
                    st_d.n   = div_of(code_i);
                    st_d.dly = dly_i;
                end
            end else begin
                st_d.cnt = st_q.cnt + CODE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.half <= 1'b0;
            st_q.n    <= RST_N;
            st_q.dly  <= RST_DLY;
            st_q.sel  <= RST_SEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign half_o = st_q.half;
    assign n_o    = st_q.n;
    assign dly_o  = st_q.dly;
    assign sel_o  = st_q.sel;

endmodule

// File: rtl/ecg_tx_shaper.sv
module ecg_tx_shaper
    import eth_clkglue_pkg::*;
#(
    parameter int CODE_W = DIV_CODE_W,
    parameter int D_W    = DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cnt_i,
    input  logic              half_i,
    input  logic [CODE_W-1:0] n_i,
    input  logic [D_W-1:0]    dly_i,
    input  logic              rgmii_i,
    input  logic              gate_i,
    input  logic              gen_i,
    output logic              tx_o,
    output logic              ref_o
);

    localparam int PW = CODE_W + D_W + 1;

    typedef struct packed {
        logic tx;
        logic rf;
    } out_t;

    out_t          st_d, st_q;
    logic [PW-1:0] phase;
    logic [PW-1:0] shift;
    logic [PW-1:0] period;
    logic [PW-1:0] skewed;
    logic [D_W-1:0] eff_dly;

    always_comb begin
        eff_dly = rgmii_i ? dly_i : '0;
        period  = PW'(n_i) << 1;
        phase   = half_i ? (PW'(n_i) + PW'(cnt_i)) : PW'(cnt_i);
        shift   = (PW'(eff_dly) * PW'(n_i)) >> 1;
        if (phase >= shift) begin
            skewed = phase - shift;
        end else begin
            skewed = phase + period - shift;
        end
        st_d.tx = gen_i & gate_i & (skewed >= PW'(n_i));
        st_d.rf = gen_i & half_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_o  = st_q.tx;
    assign ref_o = st_q.rf;

endmodule

// File: rtl/eth_clkglue.sv
module eth_clkglue
    import eth_clkglue_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter bit          ALT_MODE = 1'b0,
    parameter logic [31:0] CFG_RST  = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              ref_en0,
    input  logic              ref_en1,
    output logic              tx_clk_o,
    output logic              phy_ref_o,
    output logic              rgmii_mode_o,
    output logic              rmii_inv_o,
    output logic              mode_err_o
);

    localparam logic                  RST_SEL  = CFG_RST[POS_SEL];
    localparam logic [DIV_CODE_W-1:0] RST_CODE = CFG_RST[POS_CODE +: DIV_CODE_W];
    localparam logic [DLY_W-1:0]      RST_DLY  = CFG_RST[POS_DLY +: DLY_W];

    cfg_fields_t           fields;
    logic [DIV_CODE_W-1:0] cnt_w;
    logic                  half_w;
    logic [DIV_CODE_W-1:0] act_n_w;
    logic [DLY_W-1:0]      act_dly_w;
    logic                  act_sel_w;
    logic                  wrap_w;

    ecg_cfg_regs #(
        .DATA_W   (DATA_W),
        .ALT_MODE (ALT_MODE),
        .CFG_RST  (CFG_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .wdata_i  (cfg_wdata),
        .word_o   (cfg_rdata),
        .fields_o (fields),
        .err_o    (mode_err_o)
    );

    ecg_div_chain #(
        .CODE_W   (DIV_CODE_W),
        .D_W      (DLY_W),
        .RST_SEL  (RST_SEL),
        .RST_CODE (RST_CODE),
        .RST_DLY  (RST_DLY)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_en0 (ref_en0),
        .ref_en1 (ref_en1),
        .sel_i   (fields.sel),
        .code_i  (fields.code),
        .dly_i   (fields.dly),
        .cnt_o   (cnt_w),
        .half_o  (half_w),
        .n_o     (act_n_w),
        .dly_o   (act_dly_w),
        .sel_o   (act_sel_w),
        .wrap_o  (wrap_w)
    );

    ecg_tx_shaper #(
        .CODE_W (DIV_CODE_W),
        .D_W    (DLY_W)
    ) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_w),
        .half_i  (half_w),
        .n_i     (act_n_w),
        .dly_i   (act_dly_w),
        .rgmii_i (fields.rgmii),
        .gate_i  (fields.gate),
        .gen_i   (fields.gen),
        .tx_o    (tx_clk_o),
        .ref_o   (phy_ref_o)
    );

    assign rgmii_mode_o = fields.rgmii;
    assign rmii_inv_o   = fields.inv;

endmodule

// File: rtl/eth_clkglue_chk.sv
module eth_clkglue_chk #(
    parameter int CODE_W = 3,
    parameter int D_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_bit,
    input logic              gate_bit,
    input logic              tx_clk_o,
    input logic              phy_ref_o,
    input logic              rgmii_mode_o,
    input logic              rmii_inv_o,
    input logic              mode_err_o,
    input logic [CODE_W-1:0] act_n,
    input logic [D_W-1:0]    act_dly,
    input logic              act_sel,
    input logic              wrap
);

    a_r5_gen_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_bit |=> (!tx_clk_o && !phy_ref_o));

    a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_bit |=> !tx_clk_o);

    a_r8_inv_rmii_only: assert property (@(posedge clk) disable iff (!rst_n)
        rmii_inv_o |-> !rgmii_mode_o);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |=> mode_err_o);

    a_r3_min_divide: assert property (@(posedge clk) disable iff (!rst_n)
        act_n >= CODE_W'(2));

    a_r11_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({act_sel, act_dly, act_n}) |-> $past(wrap));

endmodule

bind eth_clkglue eth_clkglue_chk #(
    .CODE_W (eth_clkglue_pkg::DIV_CODE_W),
    .D_W    (eth_clkglue_pkg::DLY_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_bit      (cfg_rdata[eth_clkglue_pkg::POS_GEN]),
    .gate_bit     (cfg_rdata[eth_clkglue_pkg::POS_GATE]),
    .tx_clk_o     (tx_clk_o),
    .phy_ref_o    (phy_ref_o),
    .rgmii_mode_o (rgmii_mode_o),
    .rmii_inv_o   (rmii_inv_o),
    .mode_err_o   (mode_err_o),
    .act_n        (act_n_w),
    .act_dly      (act_dly_w),
    .act_sel      (act_sel_w),
    .wrap         (wrap_w)
);

// File: tb/eth_clkglue_tb_top.sv
module eth_clkglue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREC       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        ref_en0 = 1'b0;
    logic        ref_en1 = 1'b0;

    logic [31:0] rdata, alt_rdata;
    logic        tx, rf, rgmii, inv, err;
    logic        alt_tx, alt_rf, alt_rgmii, alt_inv, alt_err;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;
    logic tx_s [NREC];
    logic rf_s [NREC];

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_clkglue dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata), .ref_en0(ref_en0), .ref_en1(ref_en1),
        .tx_clk_o(tx), .phy_ref_o(rf), .rgmii_mode_o(rgmii),
        .rmii_inv_o(inv), .mode_err_o(err)
    );

    eth_clkglue #(.ALT_MODE(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(alt_rdata), .ref_en0(ref_en0), .ref_en1(ref_en1),
        .tx_clk_o(alt_tx), .phy_ref_o(alt_rf), .rgmii_mode_o(alt_rgmii),
        .rmii_inv_o(alt_inv), .mode_err_o(alt_err)
    );

    // Word layout: [2:0] mode, [4] select, [6:5] skew, [9:7] code, [10] gate, [11] invert, [12] generator.
    function automatic logic [31:0] mk(input logic [2:0] md, input logic sel, input logic [1:0] dly,
                                       input logic [2:0] code, input logic gate, input logic inv,
                                       input logic gen);
        return {19'b0, gen, inv, gate, code, dly, sel, 1'b0, md};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // One strobe every three cycles; outputs are sampled once they reflect the strobe.
    task automatic strobes(input int n, input logic m0, input logic m1, input bit rec, input int base);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ref_en0 = m0;
            ref_en1 = m1;
            @(negedge clk);
            ref_en0 = 1'b0;
            ref_en1 = 1'b0;
            @(negedge clk);
            if (rec) begin
                tx_s[base+k] = tx;
                rf_s[base+k] = rf;
            end
        end
    endtask

    task automatic apply(input logic [31:0] w);
        write_cfg(w);
        strobes(24, 1'b1, 1'b1, 1'b0, 0);
        strobes(NREC, 1'b1, 1'b1, 1'b1, 0);
    endtask

    task automatic check_wave(input int n, input int d, input string tag);
        int per_bad = 0;
        int lag_bad = 0;
        for (int i = 2*n; i < NREC; i++) begin
            if (rf_s[i] != rf_s[i-2*n] || rf_s[i] == rf_s[i-n]) per_bad++;
            if (tx_s[i] != rf_s[i-d]) lag_bad++;
        end
        chk(per_bad == 0, {tag, " reference period"}, per_bad, 0);
        chk(lag_bad == 0, {tag, " transmit lag"}, lag_bad, 0);
    endtask

    task automatic t_reset();
        chk(rdata == 32'h0, "R12 word after reset", int'(rdata), 0);
        chk(!tx && !rf, "R12 clocks low after reset", int'({tx, rf}), 0);
        chk(!err && !alt_err, "R12 error flag clear", int'({err, alt_err}), 0);
        chk(!rgmii, "R9 bit0 clear means RMII", int'(rgmii), 0);
    endtask

    task automatic t_divider();
        for (int c = 2; c < 8; c++) begin
            apply(mk(3'd1, 1'b0, 2'd0, 3'(c), 1'b1, 1'b0, 1'b1));
            check_wave(c, 0, "R2 divider code");
        end
    endtask

    task automatic t_small_codes();
        for (int c = 0; c < 2; c++) begin
            apply(mk(3'd1, 1'b0, 2'd0, 3'(c), 1'b1, 1'b0, 1'b1));
            check_wave(2, 0, "R3 small code");
        end
    endtask

    task automatic t_mux();
        int trans = 0;
        apply(mk(3'd1, 1'b1, 2'd0, 3'd3, 1'b1, 1'b0, 1'b1));
        strobes(NREC, 1'b1, 1'b0, 1'b1, 0);
        for (int i = 1; i < NREC; i++) if (rf_s[i] != rf_s[i-1]) trans++;
        chk(trans == 0, "R1 unselected input ignored", trans, 0);
        strobes(NREC, 1'b0, 1'b1, 1'b1, 0);
        check_wave(3, 0, "R1 selected input counted");
    endtask

    task automatic t_gate();
        int tx_hi = 0;
        int rf_tr = 0;
        apply(mk(3'd1, 1'b0, 2'd0, 3'd2, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < NREC; i++) tx_hi += int'(tx_s[i]);
        for (int i = 1; i < NREC; i++) if (rf_s[i] != rf_s[i-1]) rf_tr++;
        chk(tx_hi == 0, "R4 gate clear holds transmit low", tx_hi, 0);
        chk(rf_tr > 0, "R4 reference still toggles", rf_tr, 1);
    endtask

    task automatic t_gen_off();
        int hi = 0;
        apply(mk(3'd1, 1'b0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b0));
        for (int i = 0; i < NREC; i++) hi += int'(tx_s[i]) + int'(rf_s[i]);
        chk(hi == 0, "R5 generator off holds both low", hi, 0);
    endtask

    task automatic t_delay();
        for (int d = 0; d < 4; d++) begin
            apply(mk(3'd1, 1'b0, 2'(d), 3'd4, 1'b1, 1'b0, 1'b1));
            check_wave(4, (d*4)/2, "R6 skew with code 4");
            apply(mk(3'd1, 1'b0, 2'(d), 3'd5, 1'b1, 1'b0, 1'b1));
            check_wave(5, (d*5)/2, "R6 skew with code 5");
        end
        chk(rgmii == 1'b1, "R9 bit0 set means RGMII", int'(rgmii), 1);
    endtask

    task automatic t_rmii();
        apply(mk(3'd4, 1'b0, 2'd3, 3'd4, 1'b1, 1'b1, 1'b1));
        check_wave(4, 0, "R7 RMII ignores skew");
        chk(inv == 1'b1, "R8 inversion in RMII", int'(inv), 1);
        chk(alt_inv == 1'b1 && !alt_rgmii, "R10 code 4 is RMII", int'({alt_inv, alt_rgmii}), 2);
        write_cfg(mk(3'd1, 1'b0, 2'd0, 3'd4, 1'b1, 1'b1, 1'b1));
        chk(inv == 1'b0, "R8 inversion suppressed in RGMII", int'(inv), 0);
        chk(alt_rgmii && !alt_err, "R10 code 1 is RGMII, no error", int'({alt_rgmii, alt_err}), 2);
    endtask

    task automatic t_alt_err();
        write_cfg(mk(3'd3, 1'b0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b1));
        chk(alt_err && !alt_rgmii, "R10 invalid code sets error, RMII", int'({alt_err, alt_rgmii}), 2);
        chk(!err, "R10 one-bit decode never flags", int'(err), 0);
        write_cfg(mk(3'd1, 1'b0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b1));
        chk(alt_err && alt_rgmii, "R10 error stays after valid write", int'({alt_err, alt_rgmii}), 3);
    endtask

    task automatic t_boundary();
        int last_t = -1;
        int bad = 0;
        int first = 0;
        int seen2 = 0;
        apply(mk(3'd1, 1'b0, 2'd0, 3'd7, 1'b1, 1'b0, 1'b1));
        strobes(9, 1'b1, 1'b1, 1'b1, 0);
        write_cfg(mk(3'd1, 1'b0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b1));
        strobes(NREC-9, 1'b1, 1'b1, 1'b1, 9);
        for (int i = 1; i < NREC; i++) begin
            if (rf_s[i] != rf_s[i-1]) begin
                if (last_t >= 0) begin
                    if (first == 0) first = i - last_t;
                    if (i - last_t == 2) seen2++;
                    else if (i - last_t != 7) bad++;
                end
                last_t = i;
            end
        end
        chk(bad == 0, "R11 no intermediate phase length", bad, 0);
        chk(first == 7, "R11 running period keeps old length", first, 7);
        chk(seen2 > 0, "R11 new length applied", seen2, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divider();
        t_small_codes();
        t_mux();
        t_gate();
        t_gen_off();
        t_delay();
        t_rmii();
        t_alt_err();
        t_boundary();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule